// File: doc/BRIEF.md
# Ping-Pong Bulk-IN Transmit Feeder

This block sits on the transmit side of a bulk IN endpoint. It has two packet buffers of `PKT_BYTES` bytes each (64 by default), used in turn. A DMA controller fills them one byte per acknowledged transfer. While DMA is enabled, the block raises a request whenever the buffer currently being filled has a free byte. When that buffer takes its last byte, it is committed to the serial engine without any CPU action, and filling moves on to the other buffer if that buffer is free.

A packet shorter than a full buffer is committed when the CPU pulses a commit strobe. The serial engine sees the oldest committed buffer with its byte count and reads bytes in order. It then pulses packet-done, which frees the buffer and clears its count. A separate clear strobe empties both buffers. A one-cycle interrupt pulse follows each packet-done only when the interrupt-enable input is high.

Top module: `epf_dma_feeder`

## Requirements
- R1: After reset, the control register reads 0x00, `dma_req` is low, `tx_valid` is low and `irq` is low.
- R2: The control register keeps only bit 1 (DMA enable). Bits 7 to 2 and bit 0 always read 0, whatever value is written.
- R3: `dma_req` is high exactly when DMA is enabled and the buffer being filled has at least one free byte.
- R4: The DMA write that brings a buffer to `PKT_BYTES` bytes commits it. From the next cycle, `tx_valid` is high and `tx_len` equals `PKT_BYTES`.
- R5: After an automatic commit, filling continues in the other buffer if that buffer is free. When both buffers are committed, `dma_req` stays low.
- R6: A `pkt_commit` pulse commits the partly filled buffer, and `tx_len` reports its byte count.
- R7: A `pkt_commit` pulse on an empty fill buffer commits a zero-length packet (`tx_len` = 0). A pulse while both buffers are committed has no effect.
- R8: The serial side gets committed buffers oldest first. Bytes appear on `tx_data` in write order, one per `tx_rd` pulse. `tx_done` frees the buffer, clears its count and lets `dma_req` return.
- R9: Clearing the enable bit drops `dma_req` on the cycle after the write. `dma_ack` is ignored while DMA is disabled. Bytes already stored are kept and resume with the rest of the packet.
- R10: A `fifo_clr` pulse empties both buffers and returns both buffer pointers to buffer 0. On the next cycle `tx_valid` is low.
- R11: `irq` pulses high for one cycle after a `tx_done` on a committed buffer if `irq_en` is high. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data (bit 1 = DMA enable) |
| ctl_rdata | output | 8 | Control register read value |
| pkt_commit | input | 1 | CPU strobe committing the buffer being filled |
| fifo_clr | input | 1 | Empties both buffers and resets pointers |
| irq_en | input | 1 | Lets packet-done raise `irq` |
| dma_req | output | 1 | DMA transfer request |
| dma_ack | input | 1 | DMA byte transfer acknowledge (one byte) |
| dma_data | input | 8 | DMA byte |
| tx_valid | output | 1 | A committed packet is available |
| tx_len | output | clog2(PKT_BYTES+1) | Byte count of the oldest committed packet |
| tx_data | output | 8 | Current byte of the oldest committed packet |
| tx_rd | input | 1 | Advances to the next byte |
| tx_done | input | 1 | Packet sent, frees the buffer |
| irq | output | 1 | Packet-done interrupt pulse |

## Verification
The hardest state to reach is both buffers committed at once, because only then does the request fall while DMA stays enabled. The stimulus gets there by issuing two full buffers of back-to-back acknowledged DMA writes without draining either one. With both buffers held, it pulses the CPU commit strobe and then drains both packets, so an accepted stray commit would show up as an extra zero-length packet. A second hard case is a packet split by a disable, where an acknowledge arrives while disabled. The bench follows it with more bytes and a commit, then compares every byte read out.

// File: rtl/epf_pkg.sv
package epf_pkg;
   localparam int unsigned CTL_W      = 8;
   localparam int unsigned CTL_EN_BIT = 1;
   localparam int unsigned NUM_BUF    = 2;
endpackage

// File: rtl/epf_ctl_reg.sv
module epf_ctl_reg
   import epf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output logic             dma_en,
   output logic [CTL_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dma_en <= 1'b0;
      else if (wr) dma_en <= wdata[CTL_EN_BIT];
   end

   always_comb begin
      rdata             = '0;
      rdata[CTL_EN_BIT] = dma_en;
   end
endmodule

// File: rtl/epf_buf_bank.sv
module epf_buf_bank
   import epf_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PKT_BYTES = 64,
   localparam int unsigned IDX_W    = $clog2(PKT_BYTES)
)(
   input  logic              clk,
   input  logic              we,
   input  logic              wsel,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rsel,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [NUM_BUF-1:0][DATA_W-1:0] rd_b;

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      logic [DATA_W-1:0] mem [PKT_BYTES];
      always_ff @(posedge clk) begin
         if (we && (wsel == 1'(b))) mem[waddr] <= wdata;
      end
      assign rd_b[b] = mem[raddr];
   end

   assign rdata = rd_b[rsel];
endmodule

// File: rtl/epf_seq.sv
module epf_seq
   import epf_pkg::*;
#(
   parameter int unsigned PKT_BYTES = 64,
   localparam int unsigned CNT_W    = $clog2(PKT_BYTES + 1),
   localparam int unsigned IDX_W    = $clog2(PKT_BYTES)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dma_en,
   input  logic                 dma_ack,
   input  logic                 pkt_commit,
   input  logic                 fifo_clr,
   input  logic                 tx_rd,
   input  logic                 tx_done,
   output logic                 dma_req,
   output logic                 mem_we,
   output logic                 mem_wsel,
   output logic [IDX_W-1:0]     mem_waddr,
   output logic                 mem_rsel,
   output logic [IDX_W-1:0]     mem_raddr,
   output logic                 tx_valid,
   output logic [CNT_W-1:0]     tx_len,
   output logic                 pkt_release,
   output logic [NUM_BUF-1:0]   buf_ready
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PKT_BYTES - 1);

   logic [NUM_BUF-1:0][CNT_W-1:0] cnt;
   logic                          wr_sel, rd_sel;
   logic [IDX_W-1:0]              rd_idx;
   logic                          fill_open, take, last_byte, commit;

   assign fill_open   = !buf_ready[wr_sel];
   assign take        = dma_en && dma_ack && fill_open;
   assign last_byte   = take && (cnt[wr_sel] == LAST_CNT);
   assign commit      = fill_open && (last_byte || pkt_commit);
   assign pkt_release = tx_done && buf_ready[rd_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         buf_ready <= '0;
         wr_sel    <= 1'b0;
         rd_sel    <= 1'b0;
         rd_idx    <= '0;
      end else if (fifo_clr) begin
         cnt       <= '0;
         buf_ready <= '0;
         wr_sel    <= 1'b0;
         rd_sel    <= 1'b0;
         rd_idx    <= '0;
      end else begin
         for (int b = 0; b < NUM_BUF; b++) begin
            if (take && (wr_sel == 1'(b)))   cnt[b]       <= cnt[b] + 1'b1;
            if (commit && (wr_sel == 1'(b))) buf_ready[b] <= 1'b1;
            if (pkt_release && (rd_sel == 1'(b))) begin
               buf_ready[b] <= 1'b0;
               cnt[b]       <= '0;
            end
         end
         if (commit) wr_sel <= ~wr_sel;
         if (pkt_release) begin
            rd_sel <= ~rd_sel;
            rd_idx <= '0;
         end else if (tx_rd && buf_ready[rd_sel]) begin
            rd_idx <= rd_idx + 1'b1;
         end
      end
   end

   assign dma_req   = dma_en && fill_open;
   assign mem_we    = take && !fifo_clr;
   assign mem_wsel  = wr_sel;
   assign mem_waddr = cnt[wr_sel][IDX_W-1:0];
   assign mem_rsel  = rd_sel;
   assign mem_raddr = rd_idx;
   assign tx_valid  = buf_ready[rd_sel];
   assign tx_len    = cnt[rd_sel];
endmodule

// File: rtl/epf_dma_feeder.sv
module epf_dma_feeder
   import epf_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PKT_BYTES = 64
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ctl_wr,
   input  logic [CTL_W-1:0]                  ctl_wdata,
   output logic [CTL_W-1:0]                  ctl_rdata,
   input  logic                              pkt_commit,
   input  logic                              fifo_clr,
   input  logic                              irq_en,
   output logic                              dma_req,
   input  logic                              dma_ack,
   input  logic [DATA_W-1:0]                 dma_data,
   output logic                              tx_valid,
   output logic [$clog2(PKT_BYTES+1)-1:0]    tx_len,
   output logic [DATA_W-1:0]                 tx_data,
   input  logic                              tx_rd,
   input  logic                              tx_done,
   output logic                              irq
);
   localparam int unsigned IDX_W = $clog2(PKT_BYTES);

   if (PKT_BYTES < 2 || (PKT_BYTES & (PKT_BYTES - 1)) != 0) begin : g_bad_pkt
      $error("PKT_BYTES must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be positive");
   end

   logic               dma_en, mem_we, mem_wsel, mem_rsel, pkt_release;
   logic [IDX_W-1:0]   mem_waddr, mem_raddr;
   logic [NUM_BUF-1:0] buf_ready;

   epf_ctl_reg i_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctl_wr),
      .wdata (ctl_wdata),
      .dma_en(dma_en),
      .rdata (ctl_rdata)
   );

   epf_seq #(.PKT_BYTES(PKT_BYTES)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .dma_en     (dma_en),
      .dma_ack    (dma_ack),
      .pkt_commit (pkt_commit),
      .fifo_clr   (fifo_clr),
      .tx_rd      (tx_rd),
      .tx_done    (tx_done),
      .dma_req    (dma_req),
      .mem_we     (mem_we),
      .mem_wsel   (mem_wsel),
      .mem_waddr  (mem_waddr),
      .mem_rsel   (mem_rsel),
      .mem_raddr  (mem_raddr),
      .tx_valid   (tx_valid),
      .tx_len     (tx_len),
      .pkt_release(pkt_release),
      .buf_ready  (buf_ready)
   );

   epf_buf_bank #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) i_bank (
      .clk  (clk),
      .we   (mem_we),
      .wsel (mem_wsel),
      .waddr(mem_waddr),
      .wdata(dma_data),
      .rsel (mem_rsel),
      .raddr(mem_raddr),
      .rdata(tx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= pkt_release && irq_en && !fifo_clr;
   end
endmodule

// File: rtl/epf_dma_feeder_chk.sv
module epf_dma_feeder_chk #(
   parameter int unsigned PKT_BYTES = 64
)(
   input logic                           clk,
   input logic                           rst_n,
   input logic [7:0]                     ctl_rdata,
   input logic                           dma_req,
   input logic                           tx_valid,
   input logic [$clog2(PKT_BYTES+1)-1:0] tx_len,
   input logic                           tx_done,
   input logic                           irq_en,
   input logic                           fifo_clr,
   input logic                           irq,
   input logic [1:0]                     buf_ready
);
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[7:2] == 6'd0) && !ctl_rdata[0]);

   a_r3_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> ctl_rdata[1]);

   a_r5_no_req_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (&buf_ready) |-> !dma_req);

   a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_len <= ($clog2(PKT_BYTES+1))'(PKT_BYTES)));

   a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (buf_ready == 2'b00) && !tx_valid);

   a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tx_done && tx_valid && irq_en));
endmodule

bind epf_dma_feeder epf_dma_feeder_chk #(.PKT_BYTES(PKT_BYTES)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_rdata(ctl_rdata),
   .dma_req  (dma_req),
   .tx_valid (tx_valid),
   .tx_len   (tx_len),
   .tx_done  (tx_done),
   .irq_en   (irq_en),
   .fifo_clr (fifo_clr),
   .irq      (irq),
   .buf_ready(buf_ready)
);

// File: tb/test_epf_dma_feeder.sv
module test_epf_dma_feeder;
   localparam int CLK_PERIOD = 10;
   localparam int PKT = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       pkt_commit = 1'b0;
   logic       fifo_clr = 1'b0;
   logic       irq_en = 1'b0;
   logic       dma_req;
   logic       dma_ack = 1'b0;
   logic [7:0] dma_data = '0;
   logic       tx_valid;
   logic [6:0] tx_len;
   logic [7:0] tx_data;
   logic       tx_rd = 1'b0;
   logic       tx_done = 1'b0;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] byte_q [$];
   int         len_q  [$];
   int         cur_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   epf_dma_feeder i_epf_dma_feeder (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .pkt_commit(pkt_commit), .fifo_clr(fifo_clr),
      .irq_en(irq_en), .dma_req(dma_req), .dma_ack(dma_ack),
      .dma_data(dma_data), .tx_valid(tx_valid), .tx_len(tx_len),
      .tx_data(tx_data), .tx_rd(tx_rd), .tx_done(tx_done), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   // driver: feeds DMA bytes and records expected packets
   task automatic dma_push(input int n, input logic [7:0] base);
      check(dma_req === 1'b1, "R3 req before burst", int'(dma_req), 1);
      for (int i = 0; i < n; i++) begin
         dma_ack = 1'b1; dma_data = base + 8'(i * 7);
         byte_q.push_back(dma_data);
         cur_cnt++;
         if (cur_cnt == PKT) begin len_q.push_back(PKT); cur_cnt = 0; end
         @(negedge clk);
      end
      dma_ack = 1'b0;
   endtask

   task automatic commit_pulse(input bit model);
      pkt_commit = 1'b1;
      if (model) begin len_q.push_back(cur_cnt); cur_cnt = 0; end
      @(negedge clk);
      pkt_commit = 1'b0;
   endtask

   // monitor: pops expected items and compares with the serial side
   task automatic drain(input string req);
      int len;
      check(tx_valid === 1'b1, {req, " tx_valid"}, int'(tx_valid), 1);
      len = (len_q.size() > 0) ? len_q.pop_front() : -1;
      check(int'(tx_len) == len, {req, " tx_len"}, int'(tx_len), len);
      for (int i = 0; i < len; i++) begin
         logic [7:0] e;
         e = byte_q.pop_front();
         check(tx_data === e, {req, " R8 byte order"}, int'(tx_data), int'(e));
         tx_rd = 1'b1;
         @(negedge clk);
      end
      tx_rd = 1'b0;
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      check(irq === irq_en, "R11 irq after done", int'(irq), int'(irq_en));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ctl_rdata == 8'h00, "R1 ctl reset", int'(ctl_rdata), 0);
      check(dma_req === 1'b0, "R1 req reset", int'(dma_req), 0);
      check(tx_valid === 1'b0, "R1 valid reset", int'(tx_valid), 0);
      check(irq === 1'b0, "R1 irq reset", int'(irq), 0);

      // R2 only bit 1 sticks
      ctl_write(8'hFD);
      check(ctl_rdata == 8'h00, "R2 reserved bits", int'(ctl_rdata), 0);
      check(dma_req === 1'b0, "R3 req low when disabled", int'(dma_req), 0);
      ctl_write(8'hFF);
      check(ctl_rdata == 8'h02, "R2 enable bit", int'(ctl_rdata), 2);
      check(dma_req === 1'b1, "R3 req high with room", int'(dma_req), 1);

      // R4/R5 two full packets, then both busy
      irq_en = 1'b1;
      dma_push(PKT, 8'h11);
      check(tx_valid === 1'b1, "R4 auto commit", int'(tx_valid), 1);
      check(int'(tx_len) == PKT, "R4 full length", int'(tx_len), PKT);
      check(dma_req === 1'b1, "R5 req for other buffer", int'(dma_req), 1);
      dma_push(PKT, 8'h80);
      check(dma_req === 1'b0, "R5 req low both busy", int'(dma_req), 0);
      commit_pulse(1'b0);  // R7 ignored when no buffer free
      drain("R4");
      check(dma_req === 1'b1, "R8 req back after done", int'(dma_req), 1);
      drain("R5");
      check(tx_valid === 1'b0, "R7 stray commit ignored", int'(tx_valid), 0);

      // R6 short packet
      irq_en = 1'b0;
      dma_push(10, 8'h40);
      check(tx_valid === 1'b0, "R6 no auto commit short", int'(tx_valid), 0);
      commit_pulse(1'b1);
      drain("R6");

      // R7 zero-length
      commit_pulse(1'b1);
      check(int'(tx_len) == 0, "R7 zero length", int'(tx_len), 0);
      drain("R7");

      // R9 disable keeps contents, ignores ack
      dma_push(5, 8'h03);
      ctl_write(8'h00);
      check(dma_req === 1'b0, "R9 req drops", int'(dma_req), 0);
      dma_ack = 1'b1; dma_data = 8'hEE;
      @(negedge clk);
      dma_ack = 1'b0;
      check(tx_valid === 1'b0, "R9 no commit while off", int'(tx_valid), 0);
      ctl_write(8'h02);
      dma_push(3, 8'hA0);
      commit_pulse(1'b1);
      drain("R9");

      // R10 clear empties everything
      irq_en = 1'b1;
      dma_push(PKT + 7, 8'h55);
      check(tx_valid === 1'b1, "R10 precondition", int'(tx_valid), 1);
      fifo_clr = 1'b1;
      @(negedge clk);
      fifo_clr = 1'b0;
      byte_q.delete(); len_q.delete(); cur_cnt = 0;
      check(tx_valid === 1'b0, "R10 valid cleared", int'(tx_valid), 0);
      check(dma_req === 1'b1, "R10 req after clear", int'(dma_req), 1);
      dma_push(4, 8'hC1);
      commit_pulse(1'b1);
      drain("R10");
      check(tx_valid === 1'b0, "R10 nothing left", int'(tx_valid), 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule